// File: doc/BRIEF.md
# Host Transmit Command Decoder

This block sits on the read side of a host transmit FIFO. A controller asks for a packet with a one-cycle request pulse. The block then pops the command entry at the head of the FIFO and checks it. A good command is decoded into its header fields. The packet's data words are then streamed to a serializer one per cycle. The block always hands exactly one completion code back to the controller, so the controller's state machine cannot hang while it waits for a result.

When the FIFO runs dry in the middle of a data phase, the block flags a corrupted CRC to the serializer and waits out a bus-timeout interval. It then discards whatever is left of the failed packet. Discarding stops at the next start-of-packet entry or when the FIFO is empty, and the start-of-packet entry stays in the FIFO for the next request. An entry that is not a valid command is consumed and reported as an error. Such an entry never drives any other path.

Each FIFO entry is 36 bits wide: a tag in bits 35:32 and a 32-bit payload in bits 31:0.

Top module: `tx_cmd_decoder`

## Requirements
- R1: After reset, every output pulse (hdr_valid, ser_valid, ser_last, ser_bad_crc, done_valid) is low and fifo_pop is low.
- R2: A run_pkt pulse is remembered until a command is taken. No entry is popped while no request is pending, even if the FIFO holds entries. The command entry is popped exactly once when it is taken.
- R3: A command has tag 0x0 in bits 35:32. The header fields are taken from these bits: PID from 3:0, data toggle from 5:4, endpoint type from 7:6, speed from 9:8, device address from 22:16, and endpoint number from 29:23. They appear on the hdr_* ports for one cycle together with hdr_valid.
- R4: Only three PID codes are accepted: OUT (0001), IN (1001) and SETUP (1101). An IN command has no data phase and completes with status 0 (success) right after its header.
- R5: For OUT and SETUP, each following entry whose tag is neither 0x0 nor 0xF is popped and its bits 31:0 are sent on ser_data with ser_valid, in FIFO order. An entry with tag 0xF (end of packet) is popped and raises ser_last. The command then completes with status 0.
- R6: A zero-length OUT, which is a command followed directly by an end-of-packet entry, completes with status 0 and produces no ser_valid.
- R7: A taken entry whose tag is not 0x0, or whose PID is not one of the three tokens, is popped and completes with status 2 (error). No hdr_valid is produced and no data is streamed.
- R8: If the FIFO is empty during a data phase, ser_bad_crc pulses for one cycle. No further data or end-of-packet pulse follows for that packet.
- R9: After ser_bad_crc, the block waits TIMEOUT_CYC cycles. It then pops and discards entries until the FIFO is empty or a tag 0x0 entry is at the head. That entry is not popped. The command completes with status 1 (underrun).
- R10: A tag 0x0 entry met during a data phase is not popped, and the current command completes with status 2.
- R11: Every taken command produces exactly one done_valid pulse. The status code 3 is never used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_pkt | input | 1 | One-cycle request to process the next command |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_rdata | input | 36 | FIFO head entry, valid when not empty |
| fifo_pop | output | 1 | Removes the head entry at this clock edge |
| hdr_valid | output | 1 | Header fields valid for this cycle |
| hdr_pid | output | 4 | Token PID |
| hdr_toggle | output | 2 | Data toggle |
| hdr_ep_type | output | 2 | Endpoint type |
| hdr_speed | output | 2 | Endpoint speed |
| hdr_addr | output | 7 | Device address |
| hdr_ep | output | 7 | Endpoint number |
| ser_valid | output | 1 | ser_data carries a packet word |
| ser_data | output | 32 | Packet data word |
| ser_last | output | 1 | End of packet reached |
| ser_bad_crc | output | 1 | Force a corrupted CRC on the current packet |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 2 | 0 success, 1 underrun, 2 error |

## Verification
The bench runs the decoder with several packet shapes:
- OUT and SETUP packets with several data words, which tests ordering and field extraction at both small and all-ones field values.
- An IN token and a zero-length OUT, which show that the block skips or ends the data phase without waiting.
- Malformed entries: a bad tag and a frame-style PID. These test that such an entry is consumed, flagged as an error, and does not disturb later commands.

For underruns, the leftover data arrives late, during the timeout. One case ends the purge on a following command entry, which must survive in the FIFO. The other case ends the purge on an empty FIFO. A final case places a command entry in the middle of a data phase, which tests the error path that leaves the FIFO untouched.

// File: rtl/tx_cmd_pkg.sv
package tx_cmd_pkg;
    localparam int TAG_W   = 4;
    localparam int WORD_W  = 32;
    localparam int ENTRY_W = TAG_W + WORD_W;

    localparam logic [TAG_W-1:0] TAG_SOP = 4'h0;
    localparam logic [TAG_W-1:0] TAG_EOP = 4'hF;

    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_IN    = 4'b1001;
    localparam logic [3:0] PID_SETUP = 4'b1101;

    localparam logic [1:0] DONE_OK       = 2'd0;
    localparam logic [1:0] DONE_UNDERRUN = 2'd1;
    localparam logic [1:0] DONE_ERROR    = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_TMO   = 2'd2,
        ST_PURGE = 2'd3
    } st_e;

    typedef struct packed {
        logic [3:0] pid;
        logic [1:0] toggle;
        logic [1:0] ep_type;
        logic [1:0] speed;
        logic [6:0] addr;
        logic [6:0] ep;
    } cmd_t;
endpackage

// File: rtl/tx_cmd_field_decode.sv
module tx_cmd_field_decode
    import tx_cmd_pkg::*;
(
    input  logic [TAG_W-1:0] tag_i,
    input  logic [13:0]      id_i,   // entry bits 29:16 (endpoint, address)
    input  logic [9:0]       ctl_i,  // entry bits 9:0 (speed, type, toggle, pid)
    output cmd_t             cmd_o,
    output logic             is_sop_o,
    output logic             is_eop_o,
    output logic             pid_ok_o,
    output logic             needs_data_o
);
    always_comb begin
        cmd_o.ep      = id_i[13:7];
        cmd_o.addr    = id_i[6:0];
        cmd_o.speed   = ctl_i[9:8];
        cmd_o.ep_type = ctl_i[7:6];
        cmd_o.toggle  = ctl_i[5:4];
        cmd_o.pid     = ctl_i[3:0];
        is_sop_o      = (tag_i == TAG_SOP);
        is_eop_o      = (tag_i == TAG_EOP);
        pid_ok_o      = (ctl_i[3:0] == PID_OUT) || (ctl_i[3:0] == PID_IN) ||
                        (ctl_i[3:0] == PID_SETUP);
        needs_data_o  = (ctl_i[3:0] != PID_IN);
    end
endmodule

// File: rtl/tx_tmo_timer.sv
module tx_tmo_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = run_i && (cnt_q == CNT_W'(CYCLES - 1));
        cnt_d     = '0;
        if (run_i && !expired_o) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(CYCLES));
endmodule

// File: rtl/tx_cmd_decoder.sv
module tx_cmd_decoder
    import tx_cmd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_pkt,
    input  logic               fifo_empty,
    input  logic [ENTRY_W-1:0] fifo_rdata,
    output logic               fifo_pop,
    output logic               hdr_valid,
    output logic [3:0]         hdr_pid,
    output logic [1:0]         hdr_toggle,
    output logic [1:0]         hdr_ep_type,
    output logic [1:0]         hdr_speed,
    output logic [6:0]         hdr_addr,
    output logic [6:0]         hdr_ep,
    output logic               ser_valid,
    output logic [WORD_W-1:0]  ser_data,
    output logic               ser_last,
    output logic               ser_bad_crc,
    output logic               done_valid,
    output logic [1:0]         done_status
);
    typedef struct packed {
        st_e               st;
        logic              req;
        logic              hdr_valid;
        cmd_t              hdr;
        logic              ser_valid;
        logic [WORD_W-1:0] ser_data;
        logic              ser_last;
        logic              bad_crc;
        logic              done_valid;
        logic [1:0]        done_status;
    } regs_t;

    regs_t r_q, r_d;

    cmd_t dec_cmd;
    logic dec_sop, dec_eop, dec_pid_ok, dec_needs_data;
    logic tmo_expired;

    tx_cmd_field_decode u_dec (
        .tag_i        (fifo_rdata[ENTRY_W-1:WORD_W]),
        .id_i         (fifo_rdata[29:16]),
        .ctl_i        (fifo_rdata[9:0]),
        .cmd_o        (dec_cmd),
        .is_sop_o     (dec_sop),
        .is_eop_o     (dec_eop),
        .pid_ok_o     (dec_pid_ok),
        .needs_data_o (dec_needs_data)
    );

    tx_tmo_timer #(.CYCLES(TIMEOUT_CYC)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (r_q.st == ST_TMO),
        .expired_o (tmo_expired)
    );

    always_comb begin
        r_d            = r_q;
        r_d.hdr_valid  = 1'b0;
        r_d.ser_valid  = 1'b0;
        r_d.ser_last   = 1'b0;
        r_d.bad_crc    = 1'b0;
        r_d.done_valid = 1'b0;
        fifo_pop       = 1'b0;
        if (run_pkt) r_d.req = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if ((r_q.req || run_pkt) && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    r_d.req  = 1'b0;
                    if (dec_sop && dec_pid_ok) begin
                        r_d.hdr_valid = 1'b1;
                        r_d.hdr       = dec_cmd;
                        if (dec_needs_data) begin
                            r_d.st = ST_DATA;
                        end else begin
                            r_d.done_valid  = 1'b1;
                            r_d.done_status = DONE_OK;
                        end
                    end else begin
                        r_d.done_valid  = 1'b1;
                        r_d.done_status = DONE_ERROR;
                    end
                end
            end
            ST_DATA: begin
                if (fifo_empty) begin
                    r_d.bad_crc = 1'b1;
                    r_d.st      = ST_TMO;
                end else if (dec_eop) begin
                    fifo_pop        = 1'b1;
                    r_d.ser_last    = 1'b1;
                    r_d.done_valid  = 1'b1;
                    r_d.done_status = DONE_OK;
                    r_d.st          = ST_IDLE;
                end else if (dec_sop) begin
                    r_d.done_valid  = 1'b1;
                    r_d.done_status = DONE_ERROR;
                    r_d.st          = ST_IDLE;
                end else begin
                    fifo_pop      = 1'b1;
                    r_d.ser_valid = 1'b1;
                    r_d.ser_data  = fifo_rdata[WORD_W-1:0];
                end
            end
            ST_TMO: begin
                if (tmo_expired) r_d.st = ST_PURGE;
            end
            ST_PURGE: begin
                if (fifo_empty || dec_sop) begin
                    r_d.done_valid  = 1'b1;
                    r_d.done_status = DONE_UNDERRUN;
                    r_d.st          = ST_IDLE;
                end else begin
                    fifo_pop = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hdr_valid   = r_q.hdr_valid;
    assign hdr_pid     = r_q.hdr.pid;
    assign hdr_toggle  = r_q.hdr.toggle;
    assign hdr_ep_type = r_q.hdr.ep_type;
    assign hdr_speed   = r_q.hdr.speed;
    assign hdr_addr    = r_q.hdr.addr;
    assign hdr_ep      = r_q.hdr.ep;
    assign ser_valid   = r_q.ser_valid;
    assign ser_data    = r_q.ser_data;
    assign ser_last    = r_q.ser_last;
    assign ser_bad_crc = r_q.bad_crc;
    assign done_valid  = r_q.done_valid;
    assign done_status = r_q.done_status;

    a_r2_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty);
    a_r4_hdr_is_token: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> (hdr_pid == PID_OUT || hdr_pid == PID_IN || hdr_pid == PID_SETUP));
    a_r5_data_from_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(r_q.st) == ST_DATA);
    a_r8_quiet_after_bad_crc: assert property (@(posedge clk) disable iff (!rst_n)
        ser_bad_crc |=> (!ser_valid && !ser_last));
    a_r9_keep_sop: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PURGE && !fifo_empty && fifo_rdata[ENTRY_W-1:WORD_W] == TAG_SOP)
        |-> !fifo_pop);
    a_r11_done_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_status != 2'd3 && r_q.st == ST_IDLE));
endmodule

// File: tb/tx_cmd_decoder_tb.sv
`timescale 1ns/1ps
module tx_cmd_decoder_tb;
    import tx_cmd_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic run_pkt = 1'b0;
    logic fifo_empty = 1'b1;
    logic [ENTRY_W-1:0] fifo_rdata = '0;
    logic fifo_pop, hdr_valid, ser_valid, ser_last, ser_bad_crc, done_valid;
    logic [3:0] hdr_pid;
    logic [1:0] hdr_toggle, hdr_ep_type, hdr_speed, done_status;
    logic [6:0] hdr_addr, hdr_ep;
    logic [WORD_W-1:0] ser_data;

    tx_cmd_decoder #(.TIMEOUT_CYC(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_pkt(run_pkt), .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .hdr_valid(hdr_valid),
        .hdr_pid(hdr_pid), .hdr_toggle(hdr_toggle), .hdr_ep_type(hdr_ep_type),
        .hdr_speed(hdr_speed), .hdr_addr(hdr_addr), .hdr_ep(hdr_ep),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_last(ser_last),
        .ser_bad_crc(ser_bad_crc), .done_valid(done_valid), .done_status(done_status)
    );

    int checks = 0;
    int errors = 0;
    int done_seen = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // FIFO model: first-word-fall-through, pops seen at a clock edge take effect at the next falling edge
    logic [ENTRY_W-1:0] txq[$];
    logic pop_pending = 1'b0;
    always @(posedge clk) pop_pending <= fifo_pop;
    always @(negedge clk) begin
        if (pop_pending && txq.size() > 0) txq.delete(0);
        #1;
        fifo_empty = (txq.size() == 0);
        fifo_rdata = (txq.size() == 0) ? '0 : txq[0];
    end

    // scoreboard queues: stream kind 0 data, 1 last, 2 bad crc
    logic [33:0] exp_stream[$];
    string       exp_stream_req[$];
    logic [23:0] exp_hdr[$];
    string       exp_hdr_req[$];
    logic [1:0]  exp_done[$];
    string       exp_done_req[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (hdr_valid) begin
                if (exp_hdr.size() == 0) chk(1'b0, "R7 unexpected header", 64'(hdr_pid), 64'hX);
                else begin
                    chk({hdr_pid, hdr_toggle, hdr_ep_type, hdr_speed, hdr_addr, hdr_ep} == exp_hdr[0],
                        exp_hdr_req[0],
                        64'({hdr_pid, hdr_toggle, hdr_ep_type, hdr_speed, hdr_addr, hdr_ep}),
                        64'(exp_hdr[0]));
                    exp_hdr.delete(0); exp_hdr_req.delete(0);
                end
            end
            if (ser_valid || ser_last || ser_bad_crc) begin
                logic [33:0] item;
                item = ser_valid ? {2'd0, ser_data} : ser_last ? {2'd1, 32'd0} : {2'd2, 32'd0};
                if (exp_stream.size() == 0) chk(1'b0, "R5 unexpected stream item", 64'(item), 64'hX);
                else begin
                    chk(item == exp_stream[0], exp_stream_req[0], 64'(item), 64'(exp_stream[0]));
                    exp_stream.delete(0); exp_stream_req.delete(0);
                end
            end
            if (done_valid) begin
                done_seen++;
                if (exp_done.size() == 0) chk(1'b0, "R11 unexpected completion", 64'(done_status), 64'hX);
                else begin
                    chk(done_status == exp_done[0], exp_done_req[0], 64'(done_status), 64'(exp_done[0]));
                    exp_done.delete(0); exp_done_req.delete(0);
                end
            end
        end
    end

    function automatic logic [ENTRY_W-1:0] mk_cmd(input logic [3:0] tag, input logic [3:0] pid,
        input logic [1:0] tog, input logic [1:0] typ, input logic [1:0] spd,
        input logic [6:0] addr, input logic [6:0] ep);
        return {tag, 2'b00, ep, addr, 6'b000000, spd, typ, tog, pid};
    endfunction

    function automatic logic [ENTRY_W-1:0] mk_data(input logic [31:0] d);
        return {4'h3, d};
    endfunction

    localparam logic [ENTRY_W-1:0] EOP_ENTRY = {4'hF, 32'hDEAD_0000};

    task automatic push(input logic [ENTRY_W-1:0] e);
        @(negedge clk);
        txq.push_back(e);
    endtask

    task automatic exp_h(input logic [3:0] pid, input logic [1:0] tog, input logic [1:0] typ,
                         input logic [1:0] spd, input logic [6:0] addr, input logic [6:0] ep,
                         input string req);
        exp_hdr.push_back({pid, tog, typ, spd, addr, ep});
        exp_hdr_req.push_back(req);
    endtask

    task automatic exp_s(input logic [1:0] kind, input logic [31:0] d, input string req);
        exp_stream.push_back({kind, d});
        exp_stream_req.push_back(req);
    endtask

    task automatic exp_d(input logic [1:0] st, input string req);
        exp_done.push_back(st);
        exp_done_req.push_back(req);
    endtask

    task automatic run_req();
        @(negedge clk);
        run_pkt = 1'b1;
        @(negedge clk);
        run_pkt = 1'b0;
    endtask

    task automatic wait_done(input int n, input string req);
        int waited;
        waited = 0;
        while (done_seen < n && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_seen >= n, req, 64'(done_seen), 64'(n));
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nd;
        nd = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({hdr_valid, ser_valid, ser_last, ser_bad_crc, done_valid, fifo_pop} == 6'b0, "R1",
            64'({hdr_valid, ser_valid, ser_last, ser_bad_crc, done_valid, fifo_pop}), 64'd0);

        // R2, R3, R5: OUT with three words, held until requested
        push(mk_cmd(4'h0, PID_OUT, 2'd2, 2'd2, 2'd1, 7'h05, 7'h03));
        push(mk_data(32'h1111_0001));
        push(mk_data(32'h2222_0002));
        push(mk_data(32'h3333_0003));
        push(EOP_ENTRY);
        repeat (6) @(negedge clk);
        chk(txq.size() == 5, "R2 no pop without request", 64'(txq.size()), 64'd5);
        exp_h(PID_OUT, 2'd2, 2'd2, 2'd1, 7'h05, 7'h03, "R3 OUT header fields");
        exp_s(2'd0, 32'h1111_0001, "R5 word 0");
        exp_s(2'd0, 32'h2222_0002, "R5 word 1");
        exp_s(2'd0, 32'h3333_0003, "R5 word 2");
        exp_s(2'd1, 32'd0, "R5 end of packet");
        exp_d(DONE_OK, "R5 success");
        run_req(); nd++; wait_done(nd, "R11 completion OUT");
        chk(txq.size() == 0, "R2 all entries consumed", 64'(txq.size()), 64'd0);

        // R4: IN token, no data phase
        exp_h(PID_IN, 2'd1, 2'd3, 2'd2, 7'h2A, 7'h01, "R4 IN header");
        exp_d(DONE_OK, "R4 IN success");
        push(mk_cmd(4'h0, PID_IN, 2'd1, 2'd3, 2'd2, 7'h2A, 7'h01));
        run_req(); nd++; wait_done(nd, "R11 completion IN");

        // R6: zero-length OUT
        exp_h(PID_OUT, 2'd0, 2'd0, 2'd0, 7'h01, 7'h00, "R6 zero-length header");
        exp_s(2'd1, 32'd0, "R6 end of packet only");
        exp_d(DONE_OK, "R6 success");
        push(mk_cmd(4'h0, PID_OUT, 2'd0, 2'd0, 2'd0, 7'h01, 7'h00));
        push(EOP_ENTRY);
        run_req(); nd++; wait_done(nd, "R11 completion zero-length");

        // R3, R5: SETUP with all-ones fields
        exp_h(PID_SETUP, 2'd3, 2'd3, 2'd3, 7'h7F, 7'h7F, "R3 SETUP max fields");
        exp_s(2'd0, 32'hFFFF_FFFF, "R5 setup word 0");
        exp_s(2'd0, 32'h0000_0000, "R5 setup word 1");
        exp_s(2'd1, 32'd0, "R5 setup end");
        exp_d(DONE_OK, "R5 setup success");
        push(mk_cmd(4'h0, PID_SETUP, 2'd3, 2'd3, 2'd3, 7'h7F, 7'h7F));
        push({4'hE, 32'hFFFF_FFFF});
        push(mk_data(32'h0000_0000));
        push(EOP_ENTRY);
        run_req(); nd++; wait_done(nd, "R11 completion SETUP");

        // R7: bad tag
        exp_d(DONE_ERROR, "R7 bad tag error");
        push(mk_cmd(4'hC, PID_OUT, 2'd0, 2'd0, 2'd0, 7'h10, 7'h02));
        run_req(); nd++; wait_done(nd, "R11 completion bad tag");
        chk(txq.size() == 0, "R7 bad entry consumed", 64'(txq.size()), 64'd0);

        // R7: frame-style PID with start tag
        exp_d(DONE_ERROR, "R7 invalid PID error");
        push(mk_cmd(4'h0, 4'b0101, 2'd0, 2'd0, 2'd0, 7'h22, 7'h04));
        run_req(); nd++; wait_done(nd, "R11 completion bad PID");
        chk(txq.size() == 0, "R7 bad PID consumed", 64'(txq.size()), 64'd0);

        // R8, R9: underrun, leftovers arrive during timeout, purge stops at next command
        exp_h(PID_OUT, 2'd0, 2'd2, 2'd1, 7'h09, 7'h06, "R8 underrun header");
        exp_s(2'd0, 32'hAAAA_0001, "R8 word before underrun");
        exp_s(2'd2, 32'd0, "R8 bad crc");
        exp_d(DONE_UNDERRUN, "R9 underrun status");
        push(mk_cmd(4'h0, PID_OUT, 2'd0, 2'd2, 2'd1, 7'h09, 7'h06));
        push(mk_data(32'hAAAA_0001));
        run_req();
        repeat (3) @(negedge clk);
        txq.push_back(mk_data(32'hAAAA_0002));
        txq.push_back(mk_data(32'hAAAA_0003));
        txq.push_back(EOP_ENTRY);
        txq.push_back(mk_cmd(4'h0, PID_IN, 2'd2, 2'd0, 2'd0, 7'h33, 7'h05));
        nd++; wait_done(nd, "R11 completion underrun");
        chk(txq.size() == 1, "R9 start entry kept", 64'(txq.size()), 64'd1);
        exp_h(PID_IN, 2'd2, 2'd0, 2'd0, 7'h33, 7'h05, "R9 kept command header");
        exp_d(DONE_OK, "R9 kept command success");
        run_req(); nd++; wait_done(nd, "R11 completion after purge");

        // R9: purge ends on empty FIFO
        exp_h(PID_OUT, 2'd1, 2'd1, 2'd1, 7'h44, 7'h07, "R8 second underrun header");
        exp_s(2'd0, 32'hBBBB_0001, "R8 second word");
        exp_s(2'd2, 32'd0, "R8 second bad crc");
        exp_d(DONE_UNDERRUN, "R9 underrun on empty");
        push(mk_cmd(4'h0, PID_OUT, 2'd1, 2'd1, 2'd1, 7'h44, 7'h07));
        push(mk_data(32'hBBBB_0001));
        run_req(); nd++; wait_done(nd, "R11 completion empty purge");
        chk(txq.size() == 0, "R9 empty after purge", 64'(txq.size()), 64'd0);

        // R10: start entry inside data phase
        exp_h(PID_OUT, 2'd0, 2'd0, 2'd2, 7'h0C, 7'h0A, "R10 header");
        exp_s(2'd0, 32'hCCCC_0001, "R10 word");
        exp_d(DONE_ERROR, "R10 error status");
        push(mk_cmd(4'h0, PID_OUT, 2'd0, 2'd0, 2'd2, 7'h0C, 7'h0A));
        push(mk_data(32'hCCCC_0001));
        push(mk_cmd(4'h0, PID_IN, 2'd0, 2'd1, 2'd0, 7'h0D, 7'h0B));
        run_req(); nd++; wait_done(nd, "R11 completion R10");
        chk(txq.size() == 1, "R10 start entry not popped", 64'(txq.size()), 64'd1);
        exp_h(PID_IN, 2'd0, 2'd1, 2'd0, 7'h0D, 7'h0B, "R10 next command header");
        exp_d(DONE_OK, "R10 next command success");
        run_req(); nd++; wait_done(nd, "R11 completion after R10");

        repeat (4) @(negedge clk);
        chk(done_seen == nd, "R11 one completion per command", 64'(done_seen), 64'(nd));
        chk(exp_stream.size() == 0 && exp_hdr.size() == 0 && exp_done.size() == 0,
            "R11 scoreboard drained", 64'(exp_stream.size() + exp_hdr.size() + exp_done.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule